// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block is a host-attached parallel I/O peripheral with three 8-bit data ports, called A, B and C, and one control register. The host reaches it through a chip select, a two-bit address, separate read and write strobes, a write data bus and a read data bus. On the pin side, each port has an input bus for the sampled pins, an output bus driven from the port's output latch, and a per-bit output enable that follows the programmed direction.

A write to the control address does one of two things, chosen by the top data bit. If the top bit is 1, the byte is a configuration word. It sets the direction of port A, port B and the two nibbles of port C, and it clears every output latch. If the top bit is 0, the byte is a command that sets or clears one port C latch bit and leaves everything else as it was. Only plain, unstrobed input and output is implemented. The mode fields of the configuration word are stored, but every setting of them behaves as the plain mode.

Writes take effect on the rising clock edge on which chip select and the write strobe are both high. Reads are combinational while chip select and the read strobe are both high. Reset is asserted asynchronously, active low, and is released through a synchroniser.

Top module: `pio_ctrl`

## Requirements
- R1: The address selects the target: 0 is port A, 1 is port B, 2 is port C and 3 is the control register.
- R2: A control write with bit 7 = 1 sets the directions, where 1 means input and 0 means output: bit 4 for port A, bit 1 for port B, bit 3 for port C bits 7:4 and bit 0 for port C bits 3:0. The output enables of a port or nibble are all 1 exactly when it is set to output.
- R3: The mode fields of the configuration word (bits 6:5 and bit 2) do not change the directions, the read sources or the data behaviour.
- R4: A control write with bit 7 = 0 writes bit 0 into the port C latch bit selected by bits 3:1. All other latch bits and the configuration stay unchanged.
- R5: After reset, all ports are inputs (configuration 0x9B), every output latch holds 0xFF and every output enable is 0.
- R6: A read from address 3 returns 0xFF.
- R7: A write to a data port loads that port's output latch, which drives the port's output bus on the next cycle.
- R8: A read from a port or nibble set to input returns its input pins. A read from one set to output returns its latch. The two nibbles of port C choose their source independently.
- R9: A configuration word write clears the output latches of all three ports to 0x00.
- R10: A write to a port set to input still updates its latch, but the port's output enables stay 0.
- R11: Accesses with chip select low change nothing. The read bus is 0 unless chip select and the read strobe are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| addr | input | 2 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A latch output |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B latch output |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C latch output |
| pc_oe | output | 8 | Port C output enables |

## Verification
Several properties are checked on every cycle:
- the idle read bus and the constant control read value;
- that unselected cycles leave all latches and enables untouched;
- that a configuration word clears the latches;
- that a bit command changes only its selected bit while the enables hold;
- that a port A write reaches the output bus.

Some behaviour only the bench's scenarios can show:
- the per-nibble choice of read source in port C;
- that the mode fields are ignored;
- that writes to input ports are held in the latch;
- the restored defaults after a reset in the middle of a run.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned DW = 8;

  // Host address decode; the order is fixed by the register map
  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } sel_e;

  // Configuration word, MSB first to match the bit positions decoded
  typedef struct packed {
    logic       cfg_flag;  // bit 7
    logic [1:0] grp_a_md;  // bits 6:5, kept only
    logic       a_in;      // bit 4
    logic       cu_in;     // bit 3
    logic       grp_b_md;  // bit 2, kept only
    logic       b_in;      // bit 1
    logic       cl_in;     // bit 0
  } cfg_t;

  localparam logic [7:0] CFG_RST   = 8'h9B;
  localparam logic [7:0] CTL_RDVAL = 8'hFF;
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pio_cfg_reg.sv
module pio_cfg_reg
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [DW-1:0] wdata,
  output cfg_t          cfg
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= cfg_t'(CFG_RST);
    else if (cfg_we) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/pio_port_reg.sv
module pio_port_reg #(
  parameter int unsigned W      = 8,
  parameter bit          BIT_OP = 1'b0,
  localparam int unsigned SELW  = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            load,
  input  logic            bit_we,
  input  logic [SELW-1:0] bit_sel,
  input  logic            bit_val,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    q
);
  logic [W-1:0] q_r, q_d;
  logic         en;

  assign en = clear | load | (BIT_OP & bit_we);

  always_comb begin
    q_d = q_r;
    if (clear)                 q_d = '0;
    else if (load)             q_d = wdata;
    else if (BIT_OP && bit_we) q_d[bit_sel] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '1;
    else if (en) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
  import pio_pkg::*;
(
  input  logic [1:0]    addr,
  input  cfg_t          cfg,
  input  logic [DW-1:0] a_lat,
  input  logic [DW-1:0] b_lat,
  input  logic [DW-1:0] c_lat,
  input  logic [DW-1:0] a_pin,
  input  logic [DW-1:0] b_pin,
  input  logic [DW-1:0] c_pin,
  output logic [DW-1:0] rd_val
);
  localparam int unsigned HW = DW / 2;
  logic [DW-1:0] a_src, b_src, c_src;

  assign a_src = cfg.a_in ? a_pin : a_lat;
  assign b_src = cfg.b_in ? b_pin : b_lat;
  assign c_src = {cfg.cu_in ? c_pin[DW-1:HW] : c_lat[DW-1:HW],
                  cfg.cl_in ? c_pin[HW-1:0]  : c_lat[HW-1:0]};

  always_comb begin
    unique case (sel_e'(addr))
      SEL_A:   rd_val = a_src;
      SEL_B:   rd_val = b_src;
      SEL_C:   rd_val = c_src;
      default: rd_val = CTL_RDVAL;
    endcase
  end
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic [1:0]    addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  localparam int unsigned SELW = $clog2(DW);
  localparam int unsigned HW   = DW / 2;
  localparam int unsigned NP   = 3;

  logic          rst_sync_n;
  logic          host_wr, ctl_wr, cfg_we, bit_we;
  logic [NP-1:0] port_ld;
  logic [DW-1:0] lat [NP];
  logic [DW-1:0] rd_val;
  cfg_t          cfg;

  pio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // Host write decode
  assign host_wr = cs & wr;
  assign ctl_wr  = host_wr & (sel_e'(addr) == SEL_CTL);
  assign cfg_we  = ctl_wr & wdata[DW-1];
  assign bit_we  = ctl_wr & ~wdata[DW-1];

  pio_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .wdata(wdata), .cfg(cfg)
  );

  // One latch per data port; only port C takes the bit command
  for (genvar p = 0; p < NP; p++) begin : g_port
    assign port_ld[p] = host_wr & (addr == 2'(p));
    pio_port_reg #(.W(DW), .BIT_OP(p == 2)) u_lat (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .clear  (cfg_we),
      .load   (port_ld[p]),
      .bit_we (bit_we),
      .bit_sel(wdata[SELW:1]),
      .bit_val(wdata[0]),
      .wdata  (wdata),
      .q      (lat[p])
    );
  end

  assign pa_out = lat[0];
  assign pb_out = lat[1];
  assign pc_out = lat[2];

  assign pa_oe = {DW{~cfg.a_in}};
  assign pb_oe = {DW{~cfg.b_in}};
  assign pc_oe = {{HW{~cfg.cu_in}}, {HW{~cfg.cl_in}}};

  pio_rd_mux u_rmux (
    .addr(addr), .cfg(cfg),
    .a_lat(lat[0]), .b_lat(lat[1]), .c_lat(lat[2]),
    .a_pin(pa_in), .b_pin(pb_in), .c_pin(pc_in),
    .rd_val(rd_val)
  );

  assign rdata = (cs & rd) ? rd_val : '0;
endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic [1:0]    addr,
  input logic          rd,
  input logic          wr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] pa_out,
  input logic [DW-1:0] pa_oe,
  input logic [DW-1:0] pb_out,
  input logic [DW-1:0] pb_oe,
  input logic [DW-1:0] pc_out,
  input logic [DW-1:0] pc_oe
);
  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> rdata == '0);

  p_no_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out)
         && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));

  p_ctl_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs && rd && addr == 2'd3 |-> rdata == {DW{1'b1}});

  p_cfg_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs && wr && addr == 2'd3 && wdata[DW-1]
      |=> pa_out == '0 && pb_out == '0 && pc_out == '0);

  p_bit_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs && wr && addr == 2'd3 && !wdata[DW-1]
      |=> pc_out[$past(wdata[3:1])] == $past(wdata[0])
       && $countones(pc_out ^ $past(pc_out)) <= 1
       && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)
       && $stable(pa_out) && $stable(pb_out));

  p_load_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs && wr && addr == 2'd0 |=> pa_out == $past(wdata));
endmodule

bind pio_ctrl pio_ctrl_chk #(.DW(8)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
  .wdata(wdata), .rdata(rdata),
  .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
  .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/pio_ctrl_test.sv
module pio_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h5A, pb_in = 8'hC3, pc_in = 8'h96;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // Row: {req[3:0], is_wr, addr[1:0], data[7:0], exp[7:0]}
  localparam int NV = 19;
  localparam logic [22:0] TBL [NV] = '{
    {4'd8,  1'b0, 2'd0, 8'h00, 8'h5A},  // R8 port A input after reset
    {4'd8,  1'b0, 2'd2, 8'h00, 8'h96},  // R8 port C input after reset
    {4'd6,  1'b0, 2'd3, 8'h00, 8'hFF},  // R6 control read
    {4'd2,  1'b1, 2'd3, 8'h80, 8'h00},  // R2 all outputs
    {4'd9,  1'b0, 2'd0, 8'h00, 8'h00},  // R9 latch cleared
    {4'd7,  1'b1, 2'd0, 8'h3C, 8'h00},  // R7 write A
    {4'd7,  1'b0, 2'd0, 8'h00, 8'h3C},  // R7 read A latch
    {4'd1,  1'b1, 2'd1, 8'hA5, 8'h00},  // R1 write B
    {4'd1,  1'b0, 2'd1, 8'h00, 8'hA5},  // R1 read B
    {4'd1,  1'b0, 2'd0, 8'h00, 8'h3C},  // R1 A unaffected by B
    {4'd2,  1'b1, 2'd3, 8'h89, 8'h00},  // R2 C both nibbles in
    {4'd8,  1'b0, 2'd2, 8'h00, 8'h96},  // R8 C pins
    {4'd8,  1'b1, 2'd3, 8'h81, 8'h00},  // R8 C low in, high out
    {4'd4,  1'b1, 2'd3, 8'h0F, 8'h00},  // R4 set bit 7
    {4'd4,  1'b0, 2'd2, 8'h00, 8'h86},  // R4 / R8 mixed nibbles
    {4'd4,  1'b1, 2'd3, 8'h0D, 8'h00},  // R4 set bit 6
    {4'd4,  1'b0, 2'd2, 8'h00, 8'hC6},  // R4
    {4'd4,  1'b1, 2'd3, 8'h0E, 8'h00},  // R4 clear bit 7
    {4'd4,  1'b0, 2'd2, 8'h00, 8'h46}   // R4
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    #1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R5 reset state
    check("R5 pa_out", pa_out, 8'hFF);
    check("R5 pb_out", pb_out, 8'hFF);
    check("R5 pc_out", pc_out, 8'hFF);
    check("R5 oe", pa_oe | pb_oe | pc_oe, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][18]) bus_wr(TBL[i][17:16], TBL[i][15:8]);
      else begin
        bus_rd(TBL[i][17:16], v);
        check($sformatf("R%0d row%0d", TBL[i][22:19], i), v, TBL[i][7:0]);
      end
    end

    // R2 direction bits to enables
    bus_wr(2'd3, 8'h89);
    check("R2 pa_oe", pa_oe, 8'hFF);
    check("R2 pb_oe", pb_oe, 8'hFF);
    check("R2 pc_oe", pc_oe, 8'h00);

    // R3 mode fields ignored
    bus_wr(2'd3, 8'hE6);
    check("R3 pa_oe", pa_oe, 8'hFF);
    check("R3 pb_oe", pb_oe, 8'h00);
    check("R3 pc_oe", pc_oe, 8'hFF);
    bus_wr(2'd0, 8'h11);
    bus_rd(2'd0, v);
    check("R3 read A latch", v, 8'h11);

    // R10 write to an input port
    bus_wr(2'd1, 8'h77);
    check("R10 pb_out", pb_out, 8'h77);
    check("R10 pb_oe", pb_oe, 8'h00);
    bus_rd(2'd1, v);
    check("R10 read B pins", v, 8'hC3);

    // R4 bit command leaves configuration and other ports alone
    bus_wr(2'd3, 8'h03);
    check("R4 pc_out", pc_out, 8'h02);
    check("R4 pa_oe", pa_oe, 8'hFF);
    check("R4 pa_out", pa_out, 8'h11);

    // R11 unselected accesses
    bus_wr(2'd0, 8'h99, 1'b0);
    check("R11 pa_out", pa_out, 8'h11);
    bus_wr(2'd3, 8'h9B, 1'b0);
    check("R11 pa_oe", pa_oe, 8'hFF);
    bus_rd(2'd0, v, 1'b0);
    check("R11 rdata idle", v, 8'h00);
    @(negedge clk);
    cs = 1'b1; addr = 2'd3;
    #1 check("R11 rdata no rd", rdata, 8'h00);
    cs = 1'b0;

    // R5 reset mid-run
    do_reset();
    check("R5 again pa_out", pa_out, 8'hFF);
    check("R5 again pc_out", pc_out, 8'hFF);
    check("R5 again oe", pa_oe | pb_oe | pc_oe, 8'h00);
    bus_rd(2'd0, v);
    check("R5 read A pins", v, 8'h5A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule